// File: doc/BRIEF.md
# Register Scoreboard with Order Tags

This block is the central bookkeeping for a processor core that issues instructions to several functional units and lets them finish out of order. It keeps one small status entry for each architectural register: a valid flag that drops while a write to the register is outstanding, a tag naming the single functional unit that has a read pending on the register, and an order flag that records whether that read was recorded before or after the outstanding write. The order flag is what separates a read-after-write hazard, where the reader must wait, from a write-after-read hazard, where the writer must wait.

The issue stage presents a candidate instruction as a unit number, one destination and two sources, and learns combinationally whether it may issue. A unit about to fetch operands asks whether it may read them. A unit holding a result asks whether it may write it back. Operand-read completions and writebacks update the entries, and a unit waiting on a result is told one cycle after the writeback that its operand is ready. There is no renaming. A second write to a register that is still pending stalls issue.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset every register is valid with no pending reader. Any issue using a unit code other than 7 is accepted, every operand query answers ready, every writeback query answers not allowed, and no wake-up is signalled.
- R2: An accepted issue (iss_valid high while iss_ok is high) clears the valid flag of its destination from the next cycle on.
- R3: A request whose destination is not valid (a write already outstanding) gets iss_ok low.
- R4: If a source is not valid at issue, the issuing unit is recorded as a reader that came after the write. rdq_ok stays low for that unit until the register is written back, and is high afterwards.
- R5: If a source is valid at issue, the issuing unit is recorded as a reader that came before any later write. A later writer to that register may issue, but wb_ok for it stays low until the reader reports its read. The reader's rdq_ok stays high while the write is pending.
- R6: Only one reader can be recorded per register. A request naming a source that already has a recorded reader gets iss_ok low.
- R7: A writeback (wb_req high while wb_ok is high) makes the register valid again and releases its reader tag. In the next cycle wake_valid is high with wake_fu equal to the released reader's unit if a reader was recorded, and wake_valid is low otherwise.
- R8: When a writeback and an issue to the same register occur in one cycle, the issue check sees the register as already written back.
- R9: Unit code 7 (all ones) means "no unit". An issue request carrying it gets iss_ok low.
- R10: A read-done event releases a reader tag only if its unit matches the recorded reader. A mismatching unit leaves the writer blocked.
- R11: wb_ok is low for a register with no outstanding write. A request made anyway changes nothing: a recorded reader stays recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request commits when iss_ok is high |
| iss_fu | input | 3 | Functional unit of the issuing instruction |
| iss_dst | input | 4 | Destination register |
| iss_src_a | input | 4 | First source register |
| iss_src_b | input | 4 | Second source register |
| iss_ok | output | 1 | Request may issue (combinational) |
| rdq_fu | input | 3 | Unit asking to read operands |
| rdq_src_a | input | 4 | First operand register of the query |
| rdq_src_b | input | 4 | Second operand register of the query |
| rdq_ok | output | 1 | Both operands may be read now |
| wb_req | input | 1 | Writeback commits when wb_ok is high |
| wb_dst | input | 4 | Register to be written back |
| wb_ok | output | 1 | Writeback to wb_dst is allowed now |
| rdone_valid | input | 1 | A unit has finished reading a register |
| rdone_fu | input | 3 | Unit that finished reading |
| rdone_reg | input | 4 | Register it read |
| wake_valid | output | 1 | A recorded reader's operand became ready |
| wake_fu | output | 3 | Unit being woken |

## Verification
The bench builds the block with its default 16 registers and 3-bit unit codes. At this size a full sweep can confirm the reset state of every entry, and the reserved unit code 7 can be driven directly. Directed sequences then walk through each case: a reader blocked behind a writer, a writer blocked behind a reader, a reader-done event from the wrong unit, a second reader refused, and a writeback and a re-issue of the same register in one cycle.

// File: rtl/sb_pkg.sv
// Package: types shared by the register scoreboard.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package sb_pkg;

    // Which access to a register was recorded first.
    typedef enum logic {
        ORD_READ_FIRST  = 1'b0,  // reader recorded before the pending write (WAR)
        ORD_WRITE_FIRST = 1'b1   // write pending before the reader arrived (RAW)
    } sb_order_e;

endpackage

// File: rtl/sb_state_file.sv
// Module: sb_state_file
// Holds one status entry per register (valid, reader tag, order flag) and
// applies writeback, read-done and issue events. It also exposes the
// "effective" state: the current state with this cycle's writeback and
// read-done already applied, which the issue check uses.
// Assumes: iss_fire is only raised when the issue check has approved the
// request against the effective state.
module sb_state_file
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int FU_W     = 3,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wb_fire,
    input  logic [REG_W-1:0]    wb_dst,
    input  logic                rd_done,
    input  logic [FU_W-1:0]     rd_done_fu,
    input  logic [REG_W-1:0]    rd_done_reg,
    input  logic                iss_fire,
    input  logic [FU_W-1:0]     iss_fu,
    input  logic [REG_W-1:0]    iss_dst,
    input  logic [REG_W-1:0]    iss_src_a,
    input  logic [REG_W-1:0]    iss_src_b,
    output logic [NUM_REGS-1:0] cur_valid,
    output logic [FU_W-1:0]     cur_tag   [NUM_REGS],
    output sb_order_e           cur_order [NUM_REGS],
    output logic [NUM_REGS-1:0] eff_valid,
    output logic [FU_W-1:0]     eff_tag   [NUM_REGS]
);

    localparam logic [FU_W-1:0] NO_FU = '1;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
        localparam logic [REG_W-1:0] IDX = REG_W'(r);
        logic            nxt_valid;
        logic [FU_W-1:0] nxt_tag;
        sb_order_e       nxt_order;

        // Effective view: writeback first, then read-done release.
        always_comb begin
            eff_valid[r] = cur_valid[r];
            eff_tag[r]   = cur_tag[r];
            if (wb_fire && wb_dst == IDX) begin
                eff_valid[r] = 1'b1;
                eff_tag[r]   = NO_FU;
            end
            if (rd_done && rd_done_reg == IDX && eff_tag[r] == rd_done_fu) begin
                eff_tag[r] = NO_FU;
            end
        end

        // Next state: record a new reader and/or a new pending write.
        always_comb begin
            nxt_valid = eff_valid[r];
            nxt_tag   = eff_tag[r];
            nxt_order = cur_order[r];
            if (iss_fire && (iss_src_a == IDX || iss_src_b == IDX)) begin
                nxt_tag   = iss_fu;
                nxt_order = eff_valid[r] ? ORD_READ_FIRST : ORD_WRITE_FIRST;
            end
            if (iss_fire && iss_dst == IDX) begin
                nxt_valid = 1'b0;
            end
        end

        // Entry register with synchronous reset to "valid, no reader".
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_valid[r] <= 1'b1;
                cur_tag[r]   <= NO_FU;
                cur_order[r] <= ORD_READ_FIRST;
            end else begin
                cur_valid[r] <= nxt_valid;
                cur_tag[r]   <= nxt_tag;
                cur_order[r] <= nxt_order;
            end
        end
    end

endmodule

// File: rtl/sb_issue_check.sv
// Module: sb_issue_check
// Decides whether a candidate instruction may issue: the unit code must be
// real, the destination must have no outstanding write, and no source may
// already carry a recorded reader.
// Assumes: the state given is the effective (post-writeback) state.
module sb_issue_check #(
    parameter int NUM_REGS = 16,
    parameter int FU_W     = 3,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] eff_valid,
    input  logic [FU_W-1:0]     eff_tag [NUM_REGS],
    input  logic [FU_W-1:0]     iss_fu,
    input  logic [REG_W-1:0]    iss_dst,
    input  logic [REG_W-1:0]    iss_src_a,
    input  logic [REG_W-1:0]    iss_src_b,
    output logic                iss_ok
);

    localparam logic [FU_W-1:0] NO_FU = '1;

    logic src_a_free;
    logic src_b_free;

    // Per-condition checks combined into the grant.
    always_comb begin
        src_a_free = (eff_tag[iss_src_a] == NO_FU);
        src_b_free = (eff_tag[iss_src_b] == NO_FU);
        iss_ok     = (iss_fu != NO_FU) && eff_valid[iss_dst]
                     && src_a_free && src_b_free;
    end

endmodule

// File: rtl/sb_access_check.sv
// Module: sb_access_check
// Answers the operand-read query for a unit and the writeback query for a
// register. A source is readable if valid, or if the asking unit is the
// reader recorded ahead of the pending write. A writeback is allowed for a
// register with an outstanding write unless a reader is recorded ahead of it.
// Assumes: queries are made against the registered (current) state.
module sb_access_check
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int FU_W     = 3,
    parameter int NUM_SRC  = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] cur_valid,
    input  logic [FU_W-1:0]     cur_tag   [NUM_REGS],
    input  sb_order_e           cur_order [NUM_REGS],
    input  logic [FU_W-1:0]     rdq_fu,
    input  logic [REG_W-1:0]    rdq_src   [NUM_SRC],
    input  logic [REG_W-1:0]    wb_dst,
    output logic                rdq_ok,
    output logic                wb_ok
);

    localparam logic [FU_W-1:0] NO_FU = '1;

    logic [NUM_SRC-1:0] src_ready;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        // Readiness of one operand for the asking unit.
        always_comb begin
            src_ready[s] = cur_valid[rdq_src[s]]
                        || (rdq_fu != NO_FU
                            && cur_tag[rdq_src[s]] == rdq_fu
                            && cur_order[rdq_src[s]] == ORD_READ_FIRST);
        end
    end

    // Combine operand readiness and decide writeback permission.
    always_comb begin
        rdq_ok = &src_ready;
        wb_ok  = !cur_valid[wb_dst]
              && !(cur_tag[wb_dst] != NO_FU && cur_order[wb_dst] == ORD_READ_FIRST);
    end

endmodule

// File: rtl/reg_scoreboard.sv
// Module: reg_scoreboard (top)
// Centralised register scoreboard: per-register valid flag, single reader
// tag and order flag. Grants issue, operand reads and writebacks, and wakes
// a waiting reader one cycle after the register it needs is written back.
// Assumes: callers commit an issue or writeback only in a cycle where the
// matching *_ok output is high; the block itself gates the commits.
module reg_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int FU_W     = 3,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [FU_W-1:0]  iss_fu,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [REG_W-1:0] iss_src_a,
    input  logic [REG_W-1:0] iss_src_b,
    output logic             iss_ok,
    input  logic [FU_W-1:0]  rdq_fu,
    input  logic [REG_W-1:0] rdq_src_a,
    input  logic [REG_W-1:0] rdq_src_b,
    output logic             rdq_ok,
    input  logic             wb_req,
    input  logic [REG_W-1:0] wb_dst,
    output logic             wb_ok,
    input  logic             rdone_valid,
    input  logic [FU_W-1:0]  rdone_fu,
    input  logic [REG_W-1:0] rdone_reg,
    output logic             wake_valid,
    output logic [FU_W-1:0]  wake_fu
);

    localparam logic [FU_W-1:0] NO_FU = '1;

    logic [NUM_REGS-1:0] cur_valid;
    logic [FU_W-1:0]     cur_tag   [NUM_REGS];
    sb_order_e           cur_order [NUM_REGS];
    logic [NUM_REGS-1:0] eff_valid;
    logic [FU_W-1:0]     eff_tag   [NUM_REGS];
    logic [REG_W-1:0]    rdq_src   [2];
    logic                iss_fire;
    logic                wb_fire;

    // Commit strobes for the two state-changing requests.
    always_comb begin
        iss_fire   = iss_valid && iss_ok;
        wb_fire    = wb_req && wb_ok;
        rdq_src[0] = rdq_src_a;
        rdq_src[1] = rdq_src_b;
    end

    sb_state_file #(.NUM_REGS(NUM_REGS), .FU_W(FU_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .wb_fire     (wb_fire),
        .wb_dst      (wb_dst),
        .rd_done     (rdone_valid),
        .rd_done_fu  (rdone_fu),
        .rd_done_reg (rdone_reg),
        .iss_fire    (iss_fire),
        .iss_fu      (iss_fu),
        .iss_dst     (iss_dst),
        .iss_src_a   (iss_src_a),
        .iss_src_b   (iss_src_b),
        .cur_valid   (cur_valid),
        .cur_tag     (cur_tag),
        .cur_order   (cur_order),
        .eff_valid   (eff_valid),
        .eff_tag     (eff_tag)
    );

    sb_issue_check #(.NUM_REGS(NUM_REGS), .FU_W(FU_W)) u_issue (
        .eff_valid (eff_valid),
        .eff_tag   (eff_tag),
        .iss_fu    (iss_fu),
        .iss_dst   (iss_dst),
        .iss_src_a (iss_src_a),
        .iss_src_b (iss_src_b),
        .iss_ok    (iss_ok)
    );

    sb_access_check #(.NUM_REGS(NUM_REGS), .FU_W(FU_W), .NUM_SRC(2)) u_access (
        .cur_valid (cur_valid),
        .cur_tag   (cur_tag),
        .cur_order (cur_order),
        .rdq_fu    (rdq_fu),
        .rdq_src   (rdq_src),
        .wb_dst    (wb_dst),
        .rdq_ok    (rdq_ok),
        .wb_ok     (wb_ok)
    );

    // Wake-up register: report the reader released by this cycle's writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_valid <= 1'b0;
            wake_fu    <= NO_FU;
        end else begin
            wake_valid <= wb_fire && (cur_tag[wb_dst] != NO_FU);
            wake_fu    <= wb_fire ? cur_tag[wb_dst] : NO_FU;
        end
    end

    // R1: leaving reset, every entry is valid and nothing is being woken.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((&cur_valid) && !wake_valid));

    // R2: an accepted issue leaves its destination invalid.
    assert_issue_clears_dst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |=> !cur_valid[$past(iss_dst)]);

    // R3: an issue never commits on top of an outstanding write, unless that
    // write retires in the same cycle.
    assert_no_waw_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> (cur_valid[iss_dst] || (wb_fire && wb_dst == iss_dst)));

    // R7: a writeback not overlapped by a new write restores the valid flag.
    assert_wb_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_fire && !(iss_fire && iss_dst == wb_dst)) |=> cur_valid[$past(wb_dst)]);

    // R7: a wake-up is only ever the echo of a writeback one cycle earlier.
    assert_wake_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> $past(wb_fire));

    // R9: the reserved unit code never commits an issue.
    assert_no_fu_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> (iss_fu != NO_FU));

endmodule

// File: tb/reg_scoreboard_bench.sv
module reg_scoreboard_bench;

    localparam int NUM_REGS = 16;
    localparam int FU_W     = 3;
    localparam int REG_W    = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             iss_valid;
    logic [FU_W-1:0]  iss_fu;
    logic [REG_W-1:0] iss_dst, iss_src_a, iss_src_b;
    logic             iss_ok;
    logic [FU_W-1:0]  rdq_fu;
    logic [REG_W-1:0] rdq_src_a, rdq_src_b;
    logic             rdq_ok;
    logic             wb_req;
    logic [REG_W-1:0] wb_dst;
    logic             wb_ok;
    logic             rdone_valid;
    logic [FU_W-1:0]  rdone_fu;
    logic [REG_W-1:0] rdone_reg;
    logic             wake_valid;
    logic [FU_W-1:0]  wake_fu;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;  // 125 MHz

    reg_scoreboard #(.NUM_REGS(NUM_REGS), .FU_W(FU_W)) u_reg_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_fu(iss_fu), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_ok(iss_ok),
        .rdq_fu(rdq_fu), .rdq_src_a(rdq_src_a), .rdq_src_b(rdq_src_b), .rdq_ok(rdq_ok),
        .wb_req(wb_req), .wb_dst(wb_dst), .wb_ok(wb_ok),
        .rdone_valid(rdone_valid), .rdone_fu(rdone_fu), .rdone_reg(rdone_reg),
        .wake_valid(wake_valid), .wake_fu(wake_fu)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Drop every request strobe; called right after a negedge.
    task automatic idle();
        iss_valid = 1'b0; wb_req = 1'b0; rdone_valid = 1'b0;
    endtask

    // Present an issue request at the next negedge; fire selects iss_valid.
    task automatic issue(input int fu, input int dst, input int a, input int b, input bit fire);
        @(negedge clk);
        idle();
        iss_fu = FU_W'(fu); iss_dst = REG_W'(dst);
        iss_src_a = REG_W'(a); iss_src_b = REG_W'(b);
        iss_valid = fire;
        #1;
    endtask

    task automatic query(input int fu, input int a, input int b);
        rdq_fu = FU_W'(fu); rdq_src_a = REG_W'(a); rdq_src_b = REG_W'(b);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        iss_fu = '0; iss_dst = '0; iss_src_a = '0; iss_src_b = '0;
        rdq_fu = '0; rdq_src_a = '0; rdq_src_b = '0;
        wb_dst = '0; rdone_fu = '0; rdone_reg = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        #1;
        check("R1 wake_valid after reset", int'(wake_valid), 0);
        for (int r = 0; r < NUM_REGS; r++) begin
            iss_fu = 3'd0; iss_dst = REG_W'(r); iss_src_a = REG_W'(r); iss_src_b = REG_W'(r);
            wb_dst = REG_W'(r);
            query(0, r, r);
            check("R1 iss_ok reset", int'(iss_ok), 1);
            check("R1 wb_ok reset", int'(wb_ok), 0);
            check("R1 rdq_ok reset", int'(rdq_ok), 1);
        end
    endtask

    task automatic t_raw();
        do_reset();
        issue(1, 1, 2, 3, 1);
        check("R2 first issue", int'(iss_ok), 1);
        issue(2, 4, 1, 5, 1);                   // r1 pending: recorded after write
        check("R4 RAW reader may issue", int'(iss_ok), 1);
        issue(3, 1, 8, 9, 0);
        check("R3 WAW blocked", int'(iss_ok), 0);
        query(2, 1, 5);
        check("R4 RAW read blocked", int'(rdq_ok), 0);
        issue(3, 6, 1, 7, 0);
        check("R6 second reader refused", int'(iss_ok), 0);
        @(negedge clk);
        idle();
        wb_req = 1'b1; wb_dst = 4'd1;
        #1;
        check("R7 RAW writeback allowed", int'(wb_ok), 1);
        @(negedge clk);
        idle();
        query(2, 1, 5);
        check("R7 wake_valid", int'(wake_valid), 1);
        check("R7 wake_fu", int'(wake_fu), 2);
        check("R4 read ready after wb", int'(rdq_ok), 1);
        iss_fu = 3'd3; iss_dst = 4'd1; iss_src_a = 4'd8; iss_src_b = 4'd9;
        #1;
        check("R7 valid restored", int'(iss_ok), 1);
    endtask

    task automatic t_war();
        do_reset();
        issue(1, 1, 2, 3, 1);                   // fu1 reads r2,r3 first
        check("R5 reader issue", int'(iss_ok), 1);
        issue(2, 2, 4, 5, 1);
        check("R5 later writer issues", int'(iss_ok), 1);
        @(negedge clk);
        idle();
        wb_req = 1'b1; wb_dst = 4'd2;
        query(1, 2, 3);
        check("R5 writeback held", int'(wb_ok), 0);
        check("R5 earlier reader may read", int'(rdq_ok), 1);
        query(5, 2, 3);
        check("R4 non-reader blocked on pending r2", int'(rdq_ok), 0);
        @(negedge clk);
        idle();
        rdone_valid = 1'b1; rdone_fu = 3'd4; rdone_reg = 4'd2;
        @(negedge clk);
        idle();
        wb_dst = 4'd2;
        #1;
        check("R10 wrong unit keeps hold", int'(wb_ok), 0);
        rdone_valid = 1'b1; rdone_fu = 3'd1; rdone_reg = 4'd2;
        @(negedge clk);
        idle();
        wb_req = 1'b1; wb_dst = 4'd2;
        #1;
        check("R5 writeback after read", int'(wb_ok), 1);
        @(negedge clk);
        idle();
        #1;
        check("R7 no wake without reader", int'(wake_valid), 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        issue(1, 6, 7, 8, 1);
        @(negedge clk);
        idle();
        wb_req = 1'b1; wb_dst = 4'd6;
        iss_valid = 1'b1; iss_fu = 3'd2; iss_dst = 4'd6; iss_src_a = 4'd9; iss_src_b = 4'd10;
        #1;
        check("R8 issue sees writeback", int'(iss_ok), 1);
        check("R8 writeback allowed", int'(wb_ok), 1);
        issue(3, 6, 11, 12, 0);
        check("R8 re-issued write blocks", int'(iss_ok), 0);
        wb_dst = 4'd6;
        #1;
        check("R8 new write pending", int'(wb_ok), 1);
    endtask

    task automatic t_fu_code();
        do_reset();
        issue(7, 0, 1, 2, 0);
        check("R9 unit 7 refused", int'(iss_ok), 0);
        issue(6, 0, 1, 2, 0);
        check("R9 unit 6 accepted", int'(iss_ok), 1);
    endtask

    task automatic t_stray_wb();
        do_reset();
        issue(1, 0, 3, 3, 1);                   // reader on r3, r3 stays valid
        @(negedge clk);
        idle();
        wb_req = 1'b1; wb_dst = 4'd3;
        #1;
        check("R11 wb_ok without pending write", int'(wb_ok), 0);
        issue(2, 5, 3, 4, 0);
        check("R11 reader tag kept", int'(iss_ok), 0);
        check("R11 no wake", int'(wake_valid), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        iss_valid = 1'b0; wb_req = 1'b0; rdone_valid = 1'b0;
        t_reset_state();
        t_raw();
        t_war();
        t_same_cycle();
        t_fu_code();
        t_stray_wb();
        summary();
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule